// File: doc/BRIEF.md
# Parallel I/O Pin Controller

This block arbitrates a bank of up to 32 pins between on-chip peripheral functions and software-driven general-purpose I/O. For every pin, an ownership bit decides who drives the pad: the peripheral's own output and output-enable, or the controller's output-data and output-enable registers. Each frequently written register sits behind a triplet of addresses: one sets bits, one clears bits, and one reads the stored value. Software can therefore change single pins without a read-modify-write.

Every pad input goes through a synchronizer. The pin can then optionally pass through a glitch filter, which forwards a new level only after two equal consecutive synchronized samples. The resulting pin level goes to the peripheral side and can be read over the bus. Any edge of this level records a per-pin change flag. The flags clear when read. Each flag is masked by a per-pin interrupt enable, and the masked flags are OR-ed into one interrupt line.

The bus port is a simple single-cycle register port. Writes take effect at the clock edge. Read data is combinational from the address, and a read of the change-flag word clears that word at the same edge.

Top module: `pio_bank`

## Requirements
- R1: After reset, the ownership status reads all ones (every pin under controller I/O). The output-enable, output-data, filter-enable, interrupt-enable and change-flag words read zero. `pad_oe` is zero and `irq` is low.
- R2: Register groups are numbered g = 0 ownership (1 = controller I/O, 0 = peripheral), 1 output enable, 2 output data, 3 filter enable and 4 interrupt enable. Writing to word address 3g sets the bits that are one in the write data. Writing to 3g+1 clears the bits that are one. Reading 3g+2 returns the stored word.
- R3: Bits written as zero at a set or clear address keep their value. Writes to a status address (3g+2) change nothing. A read of a status address does not alter the stored word.
- R4: For each pin, `pad_out`/`pad_oe` equal the output-data/output-enable register bits when the ownership bit is 1, and equal `periph_out`/`periph_oe` when it is 0.
- R5: With the filter disabled, a pad input change appears on `periph_in` and in the level word at address 15 after the second rising clock edge that follows it, and not after the first.
- R6: With the filter enabled, a new level appears only after the fourth rising edge following the change. An input pulse lasting one clock cycle never reaches the pin level and sets no change flag.
- R7: A rising or falling edge of a pin level sets that pin's bit in the change-flag word at address 16 on the clock edge after the level changes. A one-cycle input pulse with the filter disabled does set the flag.
- R8: Reading address 16 returns the flags and clears them. An edge whose flag is being set in that same read cycle is kept, so it is not lost.
- R9: `irq` is high exactly when some pin has both its change flag and its interrupt-enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from address |
| pad_in | input | NPINS | Pad input levels (asynchronous) |
| pad_out | output | NPINS | Pad output levels |
| pad_oe | output | NPINS | Pad output enables |
| periph_out | input | NPINS | Peripheral output levels |
| periph_oe | input | NPINS | Peripheral output enables |
| periph_in | output | NPINS | Conditioned pin levels towards the peripherals |
| irq | output | 1 | Combined masked change interrupt |

## Verification
The hardest situation is a pin edge that lands in the same clock cycle as a read of the change-flag word. The read must return the old flags while the new flag survives the clear. The bench reaches this case by counting the synchronizer latency. It drives the pad on a falling edge and starts the read exactly two rising edges later, when the level has just changed but the flag is not yet registered. It then reads twice more to see the flag kept and then cleared. One-cycle glitches are placed the same way, with the filter first on and then off, to show suppression and capture side by side.

// File: rtl/pio_bank_pkg.sv
package pio_bank_pkg;
   localparam int ADDR_W = 5;
   localparam int NGRP   = 5;

   typedef enum int {
      GRP_OWN = 0,
      GRP_OE  = 1,
      GRP_OUT = 2,
      GRP_FLT = 3,
      GRP_IEN = 4
   } grp_e;

   localparam int SLOT_SET  = 0;
   localparam int SLOT_CLR  = 1;
   localparam int SLOT_STAT = 2;

   localparam logic [ADDR_W-1:0] ADR_LEVEL = ADDR_W'(15);
   localparam logic [ADDR_W-1:0] ADR_CHG   = ADDR_W'(16);

   function automatic logic [ADDR_W-1:0] grp_addr(input int g, input int slot);
      return ADDR_W'(3 * g + slot);
   endfunction
endpackage

// File: rtl/pio_sc_reg.sv
module pio_sc_reg #(
   parameter int            W       = 32,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_set,
   input  logic         wr_clr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] stat
);

   if (W < 1) begin : g_chk_w
      $error("pio_sc_reg: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stat <= RST_VAL;
      else if (wr_set) stat <= stat | wdata;
      else if (wr_clr) stat <= stat & ~wdata;
   end

   AST_SET_RAISES:   assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> ((stat & $past(wdata)) == $past(wdata)));                      // R2
   AST_CLR_LOWERS:   assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> ((stat & $past(wdata)) == '0));                                // R2
   AST_ZERO_KEEPS:   assert property (@(posedge clk) disable iff (!rst_n)
      (wr_set || wr_clr) |=> (((stat ^ $past(stat)) & ~$past(wdata)) == '0));   // R3
   AST_IDLE_STABLE:  assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_set || wr_clr) |=> $stable(stat));                                   // R3

endmodule

// File: rtl/pio_in_cond.sv
module pio_in_cond #(
   parameter int NPINS      = 32,
   parameter int SYNC_DEPTH = 2,
   parameter bit HAS_FILTER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pad_in,
   input  logic [NPINS-1:0] flt_en,
   output logic [NPINS-1:0] lvl,
   output logic [NPINS-1:0] evt
);

   if (SYNC_DEPTH < 2) begin : g_chk_sync
      $error("pio_in_cond: SYNC_DEPTH must be at least 2");
   end

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      logic [SYNC_DEPTH-1:0] chain;
      logic                  s;
      logic                  lvl_d;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[SYNC_DEPTH-2:0], pad_in[p]};
      end
      assign s = chain[SYNC_DEPTH-1];

      if (HAS_FILTER) begin : g_flt
         logic s_d;
         logic f_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s_d <= 1'b0;
               f_q <= 1'b0;
            end else begin
               s_d <= s;
               if (s == s_d) f_q <= s;
            end
         end
         assign lvl[p] = flt_en[p] ? f_q : s;

         AST_FLT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (f_q != $past(f_q)) |-> ($past(s) == $past(s, 2)));                 // R6
      end else begin : g_raw
         assign lvl[p] = s;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lvl_d <= 1'b0;
         else        lvl_d <= lvl[p];
      end
      assign evt[p] = lvl[p] ^ lvl_d;
   end

endmodule

// File: rtl/pio_bank.sv
module pio_bank
   import pio_bank_pkg::*;
#(
   parameter int NPINS      = 32,
   parameter int DATA_W     = 32,
   parameter int SYNC_DEPTH = 2,
   parameter bit HAS_FILTER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [4:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe,
   input  logic [NPINS-1:0]  periph_out,
   input  logic [NPINS-1:0]  periph_oe,
   output logic [NPINS-1:0]  periph_in,
   output logic              irq
);

   if (NPINS < 1 || NPINS > DATA_W) begin : g_chk_npins
      $error("pio_bank: NPINS must lie in 1..DATA_W");
   end

   logic                            wr_acc;
   logic                            rd_chg;
   logic [NGRP-1:0][NPINS-1:0]      grp_stat;
   logic [NPINS-1:0]                own, oe_r, out_r, flt_r, ien_r;
   logic [NPINS-1:0]                lvl, evt;
   logic [NPINS-1:0]                chg_q;

   assign wr_acc = bus_sel & bus_wr;
   assign rd_chg = bus_sel & ~bus_wr & (bus_addr == ADR_CHG);

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      localparam logic [NPINS-1:0] RV = (g == GRP_OWN) ? '1 : '0;
      pio_sc_reg #(.W(NPINS), .RST_VAL(RV)) u_reg (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_set (wr_acc && (bus_addr == grp_addr(g, SLOT_SET))),
         .wr_clr (wr_acc && (bus_addr == grp_addr(g, SLOT_CLR))),
         .wdata  (bus_wdata[NPINS-1:0]),
         .stat   (grp_stat[g])
      );
   end

   assign own   = grp_stat[GRP_OWN];
   assign oe_r  = grp_stat[GRP_OE];
   assign out_r = grp_stat[GRP_OUT];
   assign flt_r = grp_stat[GRP_FLT];
   assign ien_r = grp_stat[GRP_IEN];

   pio_in_cond #(
      .NPINS      (NPINS),
      .SYNC_DEPTH (SYNC_DEPTH),
      .HAS_FILTER (HAS_FILTER)
   ) u_cond (
      .clk    (clk),
      .rst_n  (rst_n),
      .pad_in (pad_in),
      .flt_en (flt_r),
      .lvl    (lvl),
      .evt    (evt)
   );

   assign periph_in = lvl;
   assign pad_out   = (own & out_r) | (~own & periph_out);
   assign pad_oe    = (own & oe_r)  | (~own & periph_oe);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chg_q <= '0;
      else        chg_q <= (rd_chg ? '0 : chg_q) | evt;
   end

   assign irq = |(chg_q & ien_r);

   always_comb begin
      bus_rdata = '0;
      for (int g = 0; g < NGRP; g++) begin
         if (bus_addr == grp_addr(g, SLOT_STAT)) bus_rdata[NPINS-1:0] = grp_stat[g];
      end
      if (bus_addr == ADR_LEVEL) bus_rdata[NPINS-1:0] = lvl;
      if (bus_addr == ADR_CHG)   bus_rdata[NPINS-1:0] = chg_q;
   end

   AST_CHG_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      ((chg_q & ~$past(chg_q) & ~$past(evt)) == '0));                           // R7
   AST_READ_CLEARS:    assert property (@(posedge clk) disable iff (!rst_n)
      rd_chg |=> ((chg_q & ~$past(evt)) == '0));                                // R8

endmodule

// File: tb/pio_bank_tb_top.sv
module pio_bank_tb_top;
   localparam int N = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0, bus_wr = 1'b0;
   logic [4:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0, bus_rdata;
   logic [N-1:0]  pad_in = '0, pad_out, pad_oe;
   logic [N-1:0]  periph_out = '0, periph_oe = '0, periph_in;
   logic          irq;
   int            n_chk = 0, n_fail = 0;
   logic [31:0]   exp_reg [5];
   logic [31:0]   rv;

   always #4 clk = ~clk;

   pio_bank dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
      .periph_out(periph_out), .periph_oe(periph_oe), .periph_in(periph_in),
      .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 5'(a);
      #1 d = bus_rdata;
      @(posedge clk); @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2, rv);  chk("R1 own", rv, 32'hFFFF_FFFF);
      for (int g = 1; g < 5; g++) begin
         rd(3 * g + 2, rv); chk("R1 group", rv, 32'h0);
      end
      rd(16, rv); chk("R1 chg", rv, 32'h0);
      chk("R1 pad_oe", pad_oe, 32'h0);
      chk("R1 irq", {31'b0, irq}, 32'h0);
      exp_reg[0] = '1;
      for (int g = 1; g < 5; g++) exp_reg[g] = '0;

      // R2 / R3 sweep over every group: set, clear, status-write
      for (int g = 0; g < 5; g++) begin
         for (int i = 0; i < 12; i++) begin
            logic [31:0] p;
            p = (32'(i + 1) * 32'h9E37_79B9) ^ (32'h1 << (g * 5));
            case (i % 3)
               0: begin wr(3 * g, p);     exp_reg[g] = exp_reg[g] | p;  end
               1: begin wr(3 * g + 1, p); exp_reg[g] = exp_reg[g] & ~p; end
               default: wr(3 * g + 2, p);
            endcase
            rd(3 * g + 2, rv); chk("R2 R3 triplet", rv, exp_reg[g]);
         end
         rd(3 * g + 2, rv); chk("R3 read keeps", rv, exp_reg[g]);
      end
      wr(0, '1);
      for (int g = 1; g < 5; g++) wr(3 * g + 1, '1);
      rd(16, rv); chk("R3 sweep no change flags", rv, 32'h0);

      // R4 pin multiplexing
      for (int k = 0; k < 4; k++) begin
         logic [31:0] a, b, c, d, e;
         a = 32'(k) * 32'h3C96_A55A ^ 32'h0F0F_00FF;
         b = 32'(k + 3) * 32'h1234_5677;
         c = ~b ^ 32'(k * 77);
         d = 32'hA5A5_5A5A ^ 32'(k);
         e = 32'h6996_C33C + 32'(k);
         wr(1, '1); wr(0, a);
         wr(4, '1); wr(3, b);
         wr(7, '1); wr(6, c);
         periph_out = d; periph_oe = e;
         @(negedge clk);
         chk("R4 pad_out", pad_out, (a & c) | (~a & d));
         chk("R4 pad_oe",  pad_oe,  (a & b) | (~a & e));
      end
      wr(0, '1); wr(4, '1); wr(7, '1);
      periph_out = '0; periph_oe = '0;

      // R5 unfiltered latency, R8 edge in the read cycle
      pad_in[3] = 1'b1;
      @(negedge clk); chk("R5 one edge", periph_in, 32'h0);
      @(negedge clk); chk("R5 two edges", periph_in, 32'h8);
      rd(16, rv);     chk("R8 same-cycle read", rv, 32'h0);
      rd(16, rv);     chk("R8 kept", rv, 32'h8);
      rd(16, rv);     chk("R8 cleared", rv, 32'h0);
      rd(15, rv);     chk("R5 level word", rv, 32'h8);

      // R7 falling edge, R9 masking
      pad_in[3] = 1'b0;
      idle(4);
      chk("R9 masked irq", {31'b0, irq}, 32'h0);
      wr(12, 32'h8);
      chk("R9 enabled irq", {31'b0, irq}, 32'h1);
      wr(12, 32'h4);
      chk("R9 other enable", {31'b0, irq}, 32'h1);
      wr(13, 32'h8);
      chk("R9 disabled irq", {31'b0, irq}, 32'h0);
      wr(12, 32'h8);
      rd(16, rv);     chk("R7 falling edge flag", rv, 32'h8);
      chk("R9 irq after clear", {31'b0, irq}, 32'h0);
      wr(13, '1);

      // R6 filtered latency
      wr(9, 32'h8);
      pad_in[3] = 1'b1;
      idle(3); chk("R6 three edges", periph_in, 32'h0);
      idle(1); chk("R6 four edges", periph_in, 32'h8);
      idle(3);
      rd(16, rv); chk("R7 filtered rise", rv, 32'h8);

      // R6 one-cycle low glitch is dropped
      pad_in[3] = 1'b0; @(negedge clk); pad_in[3] = 1'b1;
      idle(6);
      rd(15, rv); chk("R6 glitch level", rv, 32'h8);
      rd(16, rv); chk("R6 glitch no flag", rv, 32'h0);

      // R7 same glitch with filter off is captured
      wr(10, 32'h8);
      pad_in[3] = 1'b0; @(negedge clk); pad_in[3] = 1'b1;
      idle(6);
      rd(16, rv); chk("R7 glitch flagged", rv, 32'h8);
      rd(15, rv); chk("R5 level after glitch", rv, 32'h8);

      // R7 multi-pin pattern
      pad_in = 32'hF00F_0FF8;
      idle(4);
      rd(16, rv); chk("R7 multi-pin flags", rv, 32'hF00F_0FF0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule